// File: doc/BRIEF.md
# Up-Counting Timer with Buffered Reload

This block is a general-purpose up-counting timer. A prescaler divides the timer clock into counting ticks, and the counter steps from zero up to an active reload limit and then wraps. The block decides when an update event happens. Each update event copies the buffered prescaler value into its working register, and also copies the buffered limit when the limit is buffered. Each update event can also raise a sticky interrupt flag, under a source policy chosen by software. A separate enable for filter logic further along is produced at 1, 1/2 or 1/4 of the timer clock.

Software uses a simple word bus with a valid strobe and a write strobe. A write takes effect on the clock edge that accepts it. A read returns its data on `bus_rdata` one cycle later. The limit can be written straight into the active register, or it can be held in a preload register until the next update event. Update generation and the choice of interrupt sources are gated by separate control bits.

Top module: `upd_timer`

## Requirements
- R1: Register word indices are 0 control, 1 interrupt enable (bit 0), 2 status (bit 0 is the update flag), 3 event generate (bit 0), 4 prescaler and 5 reload limit. The control word holds counter run in bit 0, update inhibit in bit 1, overflow-only source in bit 2, reload buffering in bit 7 and the sample divider code in bits 9:8. All other control bits read as zero and ignore writes. After reset, control, interrupt enable, status, prescaler and counter are zero, and the reload limit reads all ones.
- R2: The counter holds its value while the run bit is 0, except when an event-generate write clears it.
- R3: With prescaler value P and active limit A, the counter advances once every P+1 cycles. After reaching A it returns to 0 and produces a one-cycle update pulse on `upd_evt`, so update pulses come (P+1)*(A+1) cycles apart. An overflow sets the update flag whatever the source bit says.
- R4: With buffering off (bit 7 = 0), a write to the reload limit becomes the active limit on the same clock edge.
- R5: With buffering on, a write to the reload limit is held and takes effect only at the next update event. A read of index 5 returns the written value.
- R6: With the source bit at 0, an event-generate write sets the update flag.
- R7: With the source bit at 1, an event-generate write still reloads the prescaler and limit, but it leaves the update flag unchanged.
- R8: With update inhibit set, no update pulse is produced, no buffered value is transferred and no flag is set. The counter still wraps at the active limit.
- R9: Writing 1 to bit 0 of index 3 clears the counter and the prescaler count. Index 3 always reads as 0.
- R10: The update flag stays set until software writes 0 to bit 0 of index 2; writing 1 leaves it unchanged. `irq` equals the flag AND the interrupt enable, and it changes on the same edge as either of them.
- R11: `smp_en` is high on every cycle for divider code 00 or 11, on every second cycle for code 01 and on every fourth cycle for code 10.
- R12: A written prescaler value is held and used only from the next update event onwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the read |
| cnt_o | output | CNT_W | Current counter value |
| upd_evt | output | 1 | One-cycle update event pulse |
| irq | output | 1 | Update interrupt request |
| smp_en | output | 1 | Sample-clock enable for downstream filters |

## Verification
Control, flag, interrupt and counter changes caused by a write appear on the edge that accepts the write. Read data is due one cycle after the read edge, so the scoreboard monitor compares `bus_rdata` one nanosecond after that edge. Update pulses are timed by counting falling edges from the falling edge where a pulse was seen. The bench predicts each interval as (P+1)*(A+1), includes the two edges a bus write takes, and so separates a limit taken at once from one held until the next update. The sample enable changes one edge after the divider code changes, so the bench waits one extra cycle before it counts enables over an eight-cycle window.

// File: rtl/upd_timer_pkg.sv
package upd_timer_pkg;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_IEN  = 3'd1,
    RA_STAT = 3'd2,
    RA_EVG  = 3'd3,
    RA_PSC  = 3'd4,
    RA_ARV  = 3'd5
  } reg_addr_e;

  localparam int CTL_RUN  = 0;
  localparam int CTL_UOFF = 1;
  localparam int CTL_SRC  = 2;
  localparam int CTL_SHD  = 7;
  localparam int CTL_DIV  = 8;

  typedef struct packed {
    logic [1:0] div;
    logic       shadow;
    logic       src_ovf_only;
    logic       upd_off;
    logic       run;
  } ctrl_t;

  function automatic logic [31:0] ctrl_pack(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[CTL_RUN]            = c.run;
    w[CTL_UOFF]           = c.upd_off;
    w[CTL_SRC]            = c.src_ovf_only;
    w[CTL_SHD]            = c.shadow;
    w[CTL_DIV+1:CTL_DIV]  = c.div;
    return w;
  endfunction

  function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
    ctrl_t c;
    c.run          = w[CTL_RUN];
    c.upd_off      = w[CTL_UOFF];
    c.src_ovf_only = w[CTL_SRC];
    c.shadow       = w[CTL_SHD];
    c.div          = w[CTL_DIV+1:CTL_DIV];
    return c;
  endfunction

endpackage

// File: rtl/upd_timer_regs.sv
module upd_timer_regs
  import upd_timer_pkg::*;
#(
  parameter int AW    = 3,
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             set_flag,
  output logic [31:0]      bus_rdata,
  output ctrl_t            ctrl,
  output logic             ien,
  output logic             flag,
  output logic             irq,
  output logic [CNT_W-1:0] arr_pre,
  output logic [PSC_W-1:0] psc_pre,
  output logic             sw_gen,
  output logic             arr_wr_now
);

  logic wr_en, rd_en;
  logic hit_ctrl, hit_ien, hit_stat, hit_evg, hit_psc, hit_arv;
  ctrl_t ctrl_d;
  logic  ien_d, flag_d;
  logic [31:0] rd_mux;

  assign wr_en = bus_valid && bus_write;
  assign rd_en = bus_valid && !bus_write;

  assign hit_ctrl = bus_addr == AW'(RA_CTRL);
  assign hit_ien  = bus_addr == AW'(RA_IEN);
  assign hit_stat = bus_addr == AW'(RA_STAT);
  assign hit_evg  = bus_addr == AW'(RA_EVG);
  assign hit_psc  = bus_addr == AW'(RA_PSC);
  assign hit_arv  = bus_addr == AW'(RA_ARV);

  assign sw_gen     = wr_en && hit_evg && bus_wdata[0];
  assign arr_wr_now = wr_en && hit_arv && !ctrl.shadow;

  always_comb begin
    ctrl_d = ctrl;
    if (wr_en && hit_ctrl) ctrl_d = ctrl_unpack(bus_wdata);
    ien_d = ien;
    if (wr_en && hit_ien) ien_d = bus_wdata[0];
    flag_d = flag;
    if (wr_en && hit_stat && !bus_wdata[0]) flag_d = 1'b0;
    if (set_flag) flag_d = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) rd_mux = ctrl_pack(ctrl);
    if (hit_ien)  rd_mux = {31'd0, ien};
    if (hit_stat) rd_mux = {31'd0, flag};
    if (hit_psc)  rd_mux = 32'(psc_pre);
    if (hit_arv)  rd_mux = 32'(arr_pre);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      ien       <= 1'b0;
      flag      <= 1'b0;
      irq       <= 1'b0;
      arr_pre   <= '1;
      psc_pre   <= '0;
      bus_rdata <= '0;
    end else begin
      ctrl <= ctrl_d;
      ien  <= ien_d;
      flag <= flag_d;
      irq  <= flag_d && ien_d;
      if (wr_en && hit_arv) arr_pre <= bus_wdata[CNT_W-1:0];
      if (wr_en && hit_psc) psc_pre <= bus_wdata[PSC_W-1:0];
      if (rd_en) bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/upd_timer_presc.sv
module upd_timer_presc #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic             load,
  input  logic [PSC_W-1:0] psc_pre,
  output logic             tick
);

  logic [PSC_W-1:0] psc_act;
  logic [PSC_W-1:0] psc_cnt;

  assign tick = run && (psc_cnt == psc_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_act <= '0;
      psc_cnt <= '0;
    end else begin
      if (load) psc_act <= psc_pre;
      if (clr) psc_cnt <= '0;
      else if (run) psc_cnt <= tick ? '0 : psc_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/upd_timer_cntr.sv
module upd_timer_cntr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             sw_gen,
  input  logic             upd_off,
  input  logic             src_ovf_only,
  input  logic             arr_wr_now,
  input  logic [CNT_W-1:0] arr_wdata,
  input  logic [CNT_W-1:0] arr_pre,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] arr_act,
  output logic             upd_now,
  output logic             set_flag,
  output logic             upd_evt
);

  logic ovf;

  assign ovf      = tick && (cnt_o == arr_act);
  assign upd_now  = !upd_off && (sw_gen || ovf);
  assign set_flag = !upd_off && (ovf || (sw_gen && !src_ovf_only));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o   <= '0;
      arr_act <= '1;
      upd_evt <= 1'b0;
    end else begin
      upd_evt <= upd_now;
      if (sw_gen) cnt_o <= '0;
      else if (tick) cnt_o <= ovf ? '0 : cnt_o + 1'b1;
      if (arr_wr_now) arr_act <= arr_wdata;
      else if (upd_now) arr_act <= arr_pre;
    end
  end

endmodule

// File: rtl/upd_timer_smpdiv.sv
module upd_timer_smpdiv #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       div,
  output logic             smp_en
);

  logic [DIV_W-1:0] phase;
  logic             en_d;

  always_comb begin
    unique case (div)
      2'b01:   en_d = phase[0];
      2'b10:   en_d = &phase[1:0];
      default: en_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      smp_en <= 1'b0;
    end else begin
      phase  <= phase + 1'b1;
      smp_en <= en_d;
    end
  end

endmodule

// File: rtl/upd_timer.sv
module upd_timer
  import upd_timer_pkg::*;
#(
  parameter int AW    = 3,
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_evt,
  output logic             irq,
  output logic             smp_en
);

  ctrl_t            ctrl;
  logic             ien, flag, set_flag, sw_gen, arr_wr_now;
  logic             tick, upd_now;
  logic [CNT_W-1:0] arr_pre, arr_act;
  logic [PSC_W-1:0] psc_pre;

  upd_timer_regs #(.AW(AW), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .set_flag(set_flag), .bus_rdata(bus_rdata),
    .ctrl(ctrl), .ien(ien), .flag(flag), .irq(irq),
    .arr_pre(arr_pre), .psc_pre(psc_pre),
    .sw_gen(sw_gen), .arr_wr_now(arr_wr_now)
  );

  upd_timer_presc #(.PSC_W(PSC_W)) u_presc (
    .clk(clk), .rst(rst), .run(ctrl.run), .clr(sw_gen),
    .load(upd_now), .psc_pre(psc_pre), .tick(tick)
  );

  upd_timer_cntr #(.CNT_W(CNT_W)) u_cntr (
    .clk(clk), .rst(rst), .tick(tick), .sw_gen(sw_gen),
    .upd_off(ctrl.upd_off), .src_ovf_only(ctrl.src_ovf_only),
    .arr_wr_now(arr_wr_now), .arr_wdata(bus_wdata[CNT_W-1:0]),
    .arr_pre(arr_pre), .cnt_o(cnt_o), .arr_act(arr_act),
    .upd_now(upd_now), .set_flag(set_flag), .upd_evt(upd_evt)
  );

  upd_timer_smpdiv #(.DIV_W(2)) u_smp (
    .clk(clk), .rst(rst), .div(ctrl.div), .smp_en(smp_en)
  );

endmodule

// File: rtl/upd_timer_chk.sv
module upd_timer_chk #(
  parameter int AW    = 3,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] arr_act,
  input logic             upd_evt,
  input logic             irq,
  input logic             smp_en,
  input logic             run,
  input logic             upd_off,
  input logic             shadow,
  input logic [1:0]       div,
  input logic             flag,
  input logic             ien,
  input logic             sw_gen
);

  logic stat_clr;
  assign stat_clr = bus_valid && bus_write && (bus_addr == AW'(2)) && !bus_wdata[0];

  // R2: a stopped counter keeps its value
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !sw_gen) |=> $stable(cnt_o));

  // R3: every update pulse comes with a counter at zero
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    upd_evt |-> (cnt_o == '0));

  // R5: with buffering on, the active limit moves only with an update
  a_r5_held: assert property (@(posedge clk) disable iff (rst)
    shadow |=> (upd_evt || $stable(arr_act)));

  // R8: inhibit suppresses update pulses
  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    upd_off |=> !upd_evt);

  // R10: interrupt follows flag and enable
  a_r10_irq: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && ien));

  // R10: flag is sticky until cleared by a write of 0
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !stat_clr) |=> flag);

  // R11: undivided and reserved codes give a permanent enable
  a_r11_full: assert property (@(posedge clk) disable iff (rst)
    (div == 2'b00 || div == 2'b11) |=> smp_en);

endmodule

bind upd_timer upd_timer_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_o(cnt_o),
  .arr_act(arr_act), .upd_evt(upd_evt), .irq(irq), .smp_en(smp_en),
  .run(ctrl.run), .upd_off(ctrl.upd_off), .shadow(ctrl.shadow),
  .div(ctrl.div), .flag(flag), .ien(ien), .sw_gen(sw_gen)
);

// File: tb/upd_timer_bench.sv
`timescale 1ns/1ps
module upd_timer_bench;

  localparam int AW = 3;
  localparam int CNT_W = 16;
  localparam logic [2:0] A_CTRL = 3'd0, A_IEN = 3'd1, A_STAT = 3'd2,
                         A_EVG = 3'd3, A_PSC = 3'd4, A_ARV = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [CNT_W-1:0] cnt_o;
  logic upd_evt, irq, smp_en;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mon_e;
  string       mon_t;

  always #2 clk = ~clk;

  upd_timer #(.AW(AW), .CNT_W(CNT_W), .PSC_W(16)) u_upd_timer (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_o(cnt_o), .upd_evt(upd_evt), .irq(irq), .smp_en(smp_en)
  );

  function automatic void check(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  // monitor: pops the expected read data one cycle after each read edge
  always @(posedge clk) begin
    if (bus_valid && !bus_write && !rst) begin
      #1;
      if (exp_q.size() == 0) check("scoreboard underflow", 32'd1, 32'd0);
      else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        check(mon_t, bus_rdata, mon_e);
      end
    end
  end

  task automatic gap(input int start, output int n, output int mx);
    n = start; mx = 0;
    do begin
      @(negedge clk);
      n++;
      if (int'(cnt_o) > mx) mx = int'(cnt_o);
    end while (!upd_evt && n < 400);
  endtask

  task automatic count_smp(output int ones);
    ones = 0;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (smp_en) ones++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int n, mx, ones, c0, pulses;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 reset cnt", 32'(cnt_o), 0);
    check("R1 reset irq", 32'(irq), 0);
    rd(A_CTRL, 32'h0, "R1 reset ctrl");
    rd(A_ARV, 32'h0000_FFFF, "R1 reset limit");
    rd(A_PSC, 32'h0, "R1 reset prescaler");
    rd(A_STAT, 32'h0, "R1 reset status");
    rd(A_IEN, 32'h0, "R1 reset irq enable");
    // R1 reserved bits and field layout
    wr(A_CTRL, 32'hFFFF_FC78);
    rd(A_CTRL, 32'h0, "R1 reserved bits read zero");
    wr(A_CTRL, 32'h0000_0386);
    rd(A_CTRL, 32'h0000_0386, "R1 field layout");

    // R11 sample enable rates
    count_smp(ones); check("R11 code 11 as div1", ones, 8);
    wr(A_CTRL, 32'h100); count_smp(ones); check("R11 div2", ones, 4);
    wr(A_CTRL, 32'h200); count_smp(ones); check("R11 div4", ones, 2);
    wr(A_CTRL, 32'h000); count_smp(ones); check("R11 div1", ones, 8);

    // R4/R12 setup, R6 software update, R10 flag and irq
    wr(A_ARV, 32'd4);
    wr(A_PSC, 32'd1);
    rd(A_ARV, 32'd4, "R4 limit readback");
    rd(A_PSC, 32'd1, "R12 prescaler readback");
    wr(A_EVG, 32'd1);
    check("R9 counter cleared", 32'(cnt_o), 0);
    rd(A_STAT, 32'd1, "R6 software update sets flag");
    check("R10 irq masked", 32'(irq), 0);
    wr(A_IEN, 32'd1);
    check("R10 irq raised", 32'(irq), 1);
    wr(A_STAT, 32'd1);
    rd(A_STAT, 32'd1, "R10 write 1 keeps flag");
    wr(A_STAT, 32'd0);
    rd(A_STAT, 32'd0, "R10 write 0 clears flag");
    check("R10 irq dropped", 32'(irq), 0);

    // R2 stopped counter
    repeat (5) @(negedge clk);
    check("R2 counter idle", 32'(cnt_o), 0);

    // R3 period (P+1)*(A+1) = 2*5
    wr(A_CTRL, 32'h1);
    gap(0, n, mx);
    gap(0, n, mx);
    check("R3 period", n, 10);
    check("R3 wrap at limit", mx, 4);
    rd(A_STAT, 32'd1, "R3 overflow sets flag");
    wr(A_CTRL, 32'h0);
    c0 = int'(cnt_o);
    repeat (6) @(negedge clk);
    check("R2 counter holds", 32'(cnt_o), 32'(c0));

    // R5 buffered limit
    wr(A_CTRL, 32'h81);
    gap(0, n, mx);
    wr(A_ARV, 32'd2);
    rd(A_ARV, 32'd2, "R5 preload readback");
    gap(4, n, mx);
    check("R5 old limit kept", n, 10);
    gap(0, n, mx);
    check("R5 new limit after update", n, 6);

    // R12 buffered prescaler
    wr(A_PSC, 32'd0);
    gap(2, n, mx);
    check("R12 old prescaler kept", n, 6);
    gap(0, n, mx);
    check("R12 new prescaler after update", n, 3);

    // R4 immediate limit
    wr(A_CTRL, 32'h1);
    gap(0, n, mx);
    wr(A_ARV, 32'd5);
    gap(2, n, mx);
    check("R4 immediate limit", n, 6);

    // R7 overflow-only source
    wr(A_STAT, 32'd0);
    wr(A_CTRL, 32'h4);
    wr(A_ARV, 32'd3);
    wr(A_PSC, 32'd2);
    wr(A_EVG, 32'd1);
    check("R9 counter cleared again", 32'(cnt_o), 0);
    rd(A_STAT, 32'd0, "R7 software update raises no flag");
    rd(A_EVG, 32'd0, "R9 event register reads zero");
    wr(A_CTRL, 32'h5);
    gap(0, n, mx);
    gap(0, n, mx);
    check("R7 prescaler reloaded", n, 12);
    rd(A_STAT, 32'd1, "R7 overflow still sets flag");

    // R8 update inhibit
    wr(A_CTRL, 32'h83);
    wr(A_ARV, 32'd7);
    wr(A_STAT, 32'd0);
    pulses = 0; mx = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (upd_evt) pulses++;
      if (int'(cnt_o) > mx) mx = int'(cnt_o);
    end
    check("R8 no update pulse", pulses, 0);
    check("R8 wrap at active limit", mx, 3);
    rd(A_STAT, 32'd0, "R8 no flag");
    wr(A_EVG, 32'd1);
    check("R8 generate clears counter", 32'(cnt_o), 0);
    rd(A_STAT, 32'd0, "R8 generate raises no flag");
    wr(A_CTRL, 32'h81);
    gap(0, n, mx);
    gap(0, n, mx);
    check("R8 preload transferred after release", n, 24);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule